// File: doc/BRIEF.md
# Interleaved multi-stream accumulator with a C-deep feedback ring

This block is a running-sum datapath whose single feedback loop has been rebuilt to serve several independent streams at once. The lone state register of a plain accumulator is replaced by a ring of exactly C registers. A value therefore circulates around the loop once every C clocks. Each register position in the ring holds the partial sum of a different stream. The adder inside the loop is cut into a low half and a high half, with a registered carry between them. No single clock period has to cover a full-width carry chain, so the clock can run faster than the unsplit loop allows.

Upstream logic presents one beat per clock and rotates through the streams in a fixed round-robin order. An internal modulo-C counter drives the `cur_slot` output, which names the stream whose turn it is. Every result leaves the block carrying the number of the stream it belongs to. Each stream advances only once every C clocks. Its latency in stream steps is C times that of the plain loop, while total throughput rises with the faster clock.

A per-beat clear restarts only the stream that owns the current slot. Gating by `in_valid`, the clear and reset are all built as explicit multiplexers in front of the registers. No register uses an enable pin or an asynchronous set or reset. C must be at least 2, because the two adder halves already take two of the ring's registers.

Top module: `cslow_acc`

## Requirements
- R1: A synchronous active-high reset makes `cur_slot` 0, drops `out_valid`, and sets the sum of every stream to zero.
- R2: `cur_slot` advances by one on every clock after reset and wraps from C-1 back to 0. Stream 0 owns the first beat after reset is released.
- R3: `out_valid` is high exactly two clocks after a beat with `in_valid` high, and at no other time. `out_tag` then equals the `cur_slot` value of that beat.
- R4: With `out_valid` high, `out_data` is the stream's sum modulo 2^DW of all valid beats since reset or its last clear. That sum includes the beat that produced the result.
- R5: A beat with `in_valid` low and `in_clear` low leaves its stream's sum unchanged, whatever `in_data` holds. This shows in that stream's next valid result.
- R6: A beat with `in_clear` high discards its stream's old sum. The new sum is `in_data` if `in_valid` is high, and zero otherwise.
- R7: A beat changes only the sum of the stream that owns its slot. The other C-1 streams keep their sums.
- R8: The carry out of the low half of the sum reaches the high half, and sums wrap modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Current beat carries data for the stream in the current slot |
| in_clear | input | 1 | Restart the sum of the stream in the current slot |
| in_data | input | DW | Addend for the current slot |
| cur_slot | output | clog2(C), min 1 | Stream that owns the current clock |
| out_valid | output | 1 | Result present on `out_data` |
| out_tag | output | clog2(C), min 1 | Stream number of the result |
| out_data | output | DW | Updated running sum of that stream |

## Verification
The assertions check these behaviours on every cycle:
- The step-and-wrap rule of the slot counter.
- The fixed two-clock relation between an accepted beat and `out_valid`.
- The consistency between `out_tag` and the current slot.
- The restart value after a valid clear.

The bench's scenarios are needed for everything that depends on a stream's history:
- The per-stream sums, with carries and wraparound.
- The independence of streams.
- The preservation of a sum across invalid beats that carry junk data.
- Zero sums after a reset issued mid-run.

// File: rtl/cslow_acc_pkg.sv
package cslow_acc_pkg;

    // Width of a stream number for C streams (at least one bit).
    function automatic int unsigned slot_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Width of the low half of the split adder.
    function automatic int unsigned low_bits(input int unsigned w);
        return w / 2;
    endfunction

    // Slot number reached k clocks after slot cur, for n streams.
    function automatic int unsigned slot_ahead(input int unsigned cur,
                                               input int unsigned k,
                                               input int unsigned n);
        return (cur + k) % n;
    endfunction

    // Source of the old sum fed into the adder.
    typedef enum logic [0:0] {
        SRC_STATE = 1'b0,
        SRC_ZERO  = 1'b1
    } base_sel_e;

endpackage

// File: rtl/cslow_slot_ctr.sv
module cslow_slot_ctr
    import cslow_acc_pkg::*;
#(
    parameter int unsigned C  = 4,
    parameter int unsigned TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] slot
);

    localparam logic [TW-1:0] LAST = TW'(C - 1);

    logic [TW-1:0] slot_nxt;

    // Reset is an explicit mux in front of the register.
    always_comb begin
        if (rst)
            slot_nxt = '0;
        else if (slot == LAST)
            slot_nxt = '0;
        else
            slot_nxt = slot + 1'b1;
    end

    always_ff @(posedge clk)
        slot <= slot_nxt;

    // R2: the count wraps after the last stream
    a_r2_slot_wraps: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST) |=> (slot == '0));

    // R2: otherwise the count steps by one
    a_r2_slot_steps: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST) |=> (slot == $past(slot) + 1'b1));

    // R2: the count never leaves the range of stream numbers
    a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot <= LAST));

endmodule

// File: rtl/cslow_lo_stage.sv
module cslow_lo_stage
    import cslow_acc_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned TW = 2,
    parameter int unsigned LO = 8,
    parameter int unsigned HI = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic          in_clr,
    input  logic [TW-1:0] in_tag,
    input  logic [DW-1:0] in_dat,
    input  logic [DW-1:0] fb,
    output logic          a_vld,
    output logic [TW-1:0] a_tag,
    output logic [LO-1:0] a_lo,
    output logic          a_cy,
    output logic [HI-1:0] a_base_hi,
    output logic [HI-1:0] a_dat_hi
);

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
        logic [LO-1:0] lo;
        logic          cy;
        logic [HI-1:0] base_hi;
        logic [HI-1:0] dat_hi;
    } stage_a_t;

    stage_a_t  q, d;
    base_sel_e sel;
    logic [DW-1:0] base, dat;
    logic [LO:0]   lo_full;

    always_comb begin
        // The clear selects zero in place of the circulating sum.
        sel  = in_clr ? SRC_ZERO : SRC_STATE;
        base = (sel == SRC_ZERO) ? '0 : fb;
        // The valid gate is logic, not a register enable.
        dat  = in_vld ? in_dat : '0;
        lo_full = {1'b0, base[LO-1:0]} + {1'b0, dat[LO-1:0]};
        if (rst) begin
            d = '0;
        end else begin
            d.vld     = in_vld;
            d.tag     = in_tag;
            d.lo      = lo_full[LO-1:0];
            d.cy      = lo_full[LO];
            d.base_hi = base[DW-1:LO];
            d.dat_hi  = dat[DW-1:LO];
        end
    end

    always_ff @(posedge clk)
        q <= d;

    assign a_vld     = q.vld;
    assign a_tag     = q.tag;
    assign a_lo      = q.lo;
    assign a_cy      = q.cy;
    assign a_base_hi = q.base_hi;
    assign a_dat_hi  = q.dat_hi;

    // R5: an idle beat adds nothing to the high half
    a_r5_idle_high_zero: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (a_dat_hi == '0));

    // R6: a clear removes the old high half from the sum
    a_r6_clear_high_zero: assert property (@(posedge clk) disable iff (rst)
        in_clr |=> (a_base_hi == '0));

endmodule

// File: rtl/cslow_hi_stage.sv
module cslow_hi_stage #(
    parameter int unsigned TW = 2,
    parameter int unsigned LO = 8,
    parameter int unsigned HI = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_vld,
    input  logic [TW-1:0]    a_tag,
    input  logic [LO-1:0]    a_lo,
    input  logic             a_cy,
    input  logic [HI-1:0]    a_base_hi,
    input  logic [HI-1:0]    a_dat_hi,
    output logic             b_vld,
    output logic [TW-1:0]    b_tag,
    output logic [LO+HI-1:0] b_sum
);

    typedef struct packed {
        logic             vld;
        logic [TW-1:0]    tag;
        logic [LO+HI-1:0] sum;
    } stage_b_t;

    stage_b_t q, d;
    logic [HI-1:0] hi_sum;

    always_comb begin
        hi_sum = a_base_hi + a_dat_hi + HI'(a_cy);
        if (rst) begin
            d = '0;
        end else begin
            d.vld = a_vld;
            d.tag = a_tag;
            d.sum = {hi_sum, a_lo};
        end
    end

    always_ff @(posedge clk)
        q <= d;

    assign b_vld = q.vld;
    assign b_tag = q.tag;
    assign b_sum = q.sum;

    // R8: the low half passes through the second stage unchanged
    a_r8_low_half_kept: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (b_sum[LO-1:0] == $past(a_lo)));

endmodule

// File: rtl/cslow_ring_delay.sv
module cslow_ring_delay #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    if (DEPTH == 0) begin : g_pass
        assign q = d;
    end else begin : g_chain
        logic [DW-1:0] r [DEPTH];
        // Each register carries its own explicit reset mux.
        always_ff @(posedge clk)
            r[0] <= rst ? '0 : d;
        for (genvar i = 1; i < DEPTH; i++) begin : g_tap
            always_ff @(posedge clk)
                r[i] <= rst ? '0 : r[i-1];
        end
        assign q = r[DEPTH-1];
    end

endmodule

// File: rtl/cslow_acc.sv
module cslow_acc
    import cslow_acc_pkg::*;
#(
    parameter  int unsigned DW = 16,
    parameter  int unsigned C  = 4,
    localparam int unsigned TW = slot_bits(C)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_clear,
    input  logic [DW-1:0] in_data,
    output logic [TW-1:0] cur_slot,
    output logic          out_valid,
    output logic [TW-1:0] out_tag,
    output logic [DW-1:0] out_data
);

    localparam int unsigned LO   = low_bits(DW);
    localparam int unsigned HI   = DW - LO;
    // Two ring positions sit inside the split adder, the rest in the delay.
    localparam int unsigned PAD  = C - 2;

    logic          a_vld, a_cy;
    logic [TW-1:0] a_tag;
    logic [LO-1:0] a_lo;
    logic [HI-1:0] a_base_hi, a_dat_hi;
    logic          b_vld;
    logic [TW-1:0] b_tag;
    logic [DW-1:0] b_sum;
    logic [DW-1:0] fb;

    cslow_slot_ctr #(.C(C), .TW(TW)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (cur_slot)
    );

    cslow_lo_stage #(.DW(DW), .TW(TW), .LO(LO), .HI(HI)) u_lo (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_valid),
        .in_clr    (in_clear),
        .in_tag    (cur_slot),
        .in_dat    (in_data),
        .fb        (fb),
        .a_vld     (a_vld),
        .a_tag     (a_tag),
        .a_lo      (a_lo),
        .a_cy      (a_cy),
        .a_base_hi (a_base_hi),
        .a_dat_hi  (a_dat_hi)
    );

    cslow_hi_stage #(.TW(TW), .LO(LO), .HI(HI)) u_hi (
        .clk       (clk),
        .rst       (rst),
        .a_vld     (a_vld),
        .a_tag     (a_tag),
        .a_lo      (a_lo),
        .a_cy      (a_cy),
        .a_base_hi (a_base_hi),
        .a_dat_hi  (a_dat_hi),
        .b_vld     (b_vld),
        .b_tag     (b_tag),
        .b_sum     (b_sum)
    );

    cslow_ring_delay #(.DW(DW), .DEPTH(PAD)) u_ring (
        .clk (clk),
        .rst (rst),
        .d   (b_sum),
        .q   (fb)
    );

    assign out_valid = b_vld;
    assign out_tag   = b_tag;
    assign out_data  = b_sum;

    // R3: a result appears exactly two clocks after an accepted beat
    a_r3_valid_lag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

    // R3: the tag names the stream that was in the slot two clocks earlier
    a_r3_tag_matches_slot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (slot_ahead(int'(out_tag), 2, C) == int'(cur_slot)));

    // R6: a valid clear restarts the sum at the beat's data
    a_r6_clear_restart: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(in_valid && in_clear, 2))
        |-> (out_valid && out_data == $past(in_data, 2)));

endmodule

// File: tb/cslow_acc_tb_top.sv
module cslow_acc_tb_top;

    localparam int DW = 8;
    localparam int C  = 3;
    localparam int TW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_clear = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [TW-1:0] cur_slot, out_tag;
    logic          out_valid;
    logic [DW-1:0] out_data;

    cslow_acc #(.DW(DW), .C(C)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_clear  (in_clear),
        .in_data   (in_data),
        .cur_slot  (cur_slot),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_data  (out_data)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [DW-1:0] ref_acc [C];
    int            slot_m;
    logic          ev [2];
    logic [DW-1:0] ed [2];
    int            et [2];
    string         er [2];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < C; i++) ref_acc[i] = '0;
        for (int i = 0; i < 2; i++) begin
            ev[i] = 1'b0; ed[i] = '0; et[i] = 0; er[i] = "R1";
        end
        slot_m = 0;
    endtask

    // Called at a falling edge: check the beat from two steps back, drive the next.
    task automatic beat(input bit v, input bit c, input logic [DW-1:0] d, input string req);
        chk(out_valid == ev[1], "R3 out_valid", int'(out_valid), int'(ev[1]));
        if (ev[1]) begin
            chk(int'(out_tag) == et[1], "R3 out_tag", int'(out_tag), et[1]);
            chk(out_data == ed[1], {er[1], " out_data"}, int'(out_data), int'(ed[1]));
        end
        chk(int'(cur_slot) == slot_m, "R2 cur_slot", int'(cur_slot), slot_m);
        ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0]; er[1] = er[0];
        if (c) ref_acc[slot_m] = '0;
        if (v) ref_acc[slot_m] = ref_acc[slot_m] + d;
        ev[0] = v; ed[0] = ref_acc[slot_m]; et[0] = slot_m; er[0] = req;
        in_valid = v; in_clear = c; in_data = d;
        slot_m = (slot_m + 1) % C;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_clear = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(cur_slot == '0, "R1 cur_slot in reset", int'(cur_slot), 0);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: every stream starts from zero
        for (int i = 0; i < 2 * C; i++) beat(1'b1, 1'b0, '0, "R1");
        // R8, R4: every data value into every stream, forcing carries and wraps
        for (int v = 0; v < 256; v++)
            for (int s = 0; s < C; s++) beat(1'b1, 1'b0, DW'(v + 17 * s), "R8");
        // R5: idle beats carry junk data that must not count
        for (int i = 0; i < 300; i++)
            beat((i % 4) != 1, 1'b0, DW'(i * 53 + 7), "R5");
        // R6, R7: clears land on rotating slots, with and without data
        for (int i = 0; i < 300; i++) begin
            bit c = (i % 7) == 2;
            beat((i % 5) != 3, c, DW'(i * 29 + 3), c ? "R6" : "R7");
        end
        // R4: long accumulation per stream with mixed values
        for (int i = 0; i < 240; i++)
            beat(1'b1, 1'b0, DW'(i * i + 101), "R4");
        // R1: reset in mid-run wipes every stream
        do_reset();
        for (int i = 0; i < 2 * C; i++) beat(1'b1, 1'b0, DW'(i + 1), "R1");
        // R3: drain with idle beats, no results must appear
        for (int i = 0; i < 4; i++) beat(1'b0, 1'b0, 8'hA5, "R3");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule